// File: doc/BRIEF.md
# Nibble-Carry Add/Subtract Unit

A purely combinational arithmetic unit for a small microcontroller-style datapath. It takes two operands of width `W`, a carry vector, an overflow flag and a 2-bit operation code. It returns the result together with a carry vector and an overflow bit. The unit has no single carry out. It reports a carry (for addition) or a borrow (for subtraction) at every 4-bit group boundary of the operand. The most significant entry of the vector always describes the full operand width. This gives the surrounding flag logic an auxiliary nibble carry for decimal adjustment and a main carry in the same vector.

The incoming carry vector uses the same layout. Only its most significant bit is consumed, and only as the carry into add-with-carry or as the borrow into subtract. The width parameter is legal from 1 to 11 bits.

Top module: `nibble_addsub`

## Requirements
- R1: The carry vector has NG = (W-1)/4+1 bits. Bit h describes the low min(4*(h+1), W) operand bits, so the top bit always covers the full width, even when W is not a multiple of 4.
- R2: With op_i = 2'b00 (add), res_o = (A+B) mod 2^W, and cy_o[h] is 1 exactly when the low-field sum of A and B exceeds that field's maximum. cy_i has no effect.
- R3: With op_i = 2'b01 (add with carry), using cin = cy_i[NG-1], res_o = (A+B+cin) mod 2^W, and cy_o[h] is 1 exactly when the low-field sum including cin exceeds the field's maximum.
- R4: With op_i = 2'b10 (subtract with borrow), using cin = cy_i[NG-1], res_o = (A-B-cin) mod 2^W, and cy_o[h] is 1 exactly when the low field of A, minus that of B, minus cin, is negative.
- R5: ov_o for ops 00/01/10 equals the full-width carry (or borrow) out XOR the carry (or borrow) out of the low W-1 bits, which is the same as signed two's-complement overflow.
- R6: With op_i = 2'b11, res_o, cy_o and ov_o are all zero.
- R7: cy_i[NG-2:0] and ov_i never affect any output.
- R8: For W = 1 the low W-1 field is empty, so its carry out equals the carry in, and ov_o = cin_effective XOR carry out.
- R9: No clock or state is involved. Outputs depend only on the current inputs and settle within one propagation window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand (subtrahend for op 10) |
| cy_i | input | NG | Incoming carry vector; only the top bit is used |
| ov_i | input | 1 | Incoming overflow flag (ignored) |
| op_i | input | 2 | 00 add, 01 add with carry, 10 subtract with borrow, 11 clear |
| res_o | output | W | Result |
| cy_o | output | NG | Carry/borrow at each 4-bit group boundary |
| ov_o | output | 1 | Signed overflow |

## Verification
The bound checker evaluates every input combination as it appears. It compares the result and the top carry against whole-word arithmetic, the overflow against the sign-bit rule, and each group bit against a masked low-field sum. It also confirms that the clear code leaves every output quiet. Only the bench's sweeps can show that the lower carry-vector bits and the incoming overflow flag are truly ignored. The same holds for the behaviour at every instantiated width from 1 to 8, including the degenerate 1-bit case and widths with a partial top group.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SBB = 2'b10,
    OP_CLR = 2'b11
  } addsub_op_e;

  // number of 4-bit groups for an operand width
  function automatic int grp_cnt(input int w);
    return (w - 1) / 4 + 1;
  endfunction

  // bit position of the carry that closes group h
  function automatic int grp_edge(input int w, input int h);
    return ((h + 1) * 4 < w) ? (h + 1) * 4 : w;
  endfunction

endpackage

// File: rtl/addsub_prep.sv
module addsub_prep
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] b_eff_o,
  output logic         c0_o,
  output logic         sub_o,
  output logic         kill_o
);

  addsub_op_e op;

  always_comb begin
    op      = addsub_op_e'(op_i);
    sub_o   = 1'b0;
    kill_o  = 1'b0;
    c0_o    = 1'b0;
    b_eff_o = b_i;
    unique case (op)
      OP_ADD: c0_o = 1'b0;
      OP_ADC: c0_o = cin_i;
      OP_SBB: begin
        // A - B - cin == A + ~B + ~cin ; borrow = ~carry
        sub_o   = 1'b1;
        b_eff_o = ~b_i;
        c0_o    = ~cin_i;
      end
      OP_CLR: kill_o = 1'b1;
      default: kill_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c0_i,
  output logic [W-1:0] sum_o,
  output logic [W:0]   carry_o
);

  assign carry_o[0] = c0_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry_o[i];
    assign carry_o[i+1] = (a_i[i] & b_i[i]) | (carry_o[i] & (a_i[i] ^ b_i[i]));
  end

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int W  = 8,
  parameter int NG = grp_cnt(W)
) (
  input  logic [W:0]    carry_i,
  input  logic          sub_i,
  input  logic          kill_i,
  output logic [NG-1:0] cy_o,
  output logic          ov_o
);

  for (genvar h = 0; h < NG; h++) begin : g_grp
    localparam int EDGE = grp_edge(W, h);
    // carry for add, inverted carry (borrow) for subtract
    assign cy_o[h] = ~kill_i & (carry_i[EDGE] ^ sub_i);
  end

  // carry into sign bit vs carry out of it; inversion cancels for subtract
  assign ov_o = ~kill_i & (carry_i[W] ^ carry_i[W-1]);

endmodule

// File: rtl/nibble_addsub.sv
module nibble_addsub
  import addsub_pkg::*;
#(
  parameter int W = 8,
  localparam int NG = grp_cnt(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [NG-1:0] cy_i,
  input  logic          ov_i,
  input  logic [1:0]    op_i,
  output logic [W-1:0]  res_o,
  output logic [NG-1:0] cy_o,
  output logic          ov_o
);

  logic [W-1:0] b_eff;
  logic         c0;
  logic         sub;
  logic         kill;
  logic [W-1:0] sum;
  logic [W:0]   carry;
  logic         unused_flag_bits;

  // only the top carry bit is consumed
  assign unused_flag_bits = ^{cy_i, ov_i};

  addsub_prep #(.W(W)) u_prep (
    .b_i    (b_i),
    .cin_i  (cy_i[NG-1]),
    .op_i   (op_i),
    .b_eff_o(b_eff),
    .c0_o   (c0),
    .sub_o  (sub),
    .kill_o (kill)
  );

  addsub_ripple #(.W(W)) u_ripple (
    .a_i    (a_i),
    .b_i    (b_eff),
    .c0_i   (c0),
    .sum_o  (sum),
    .carry_o(carry)
  );

  addsub_flags #(.W(W), .NG(NG)) u_flags (
    .carry_i(carry),
    .sub_i  (sub),
    .kill_i (kill),
    .cy_o   (cy_o),
    .ov_o   (ov_o)
  );

  assign res_o = kill ? '0 : sum;

endmodule

// File: rtl/nibble_addsub_chk.sv
module nibble_addsub_chk
  import addsub_pkg::*;
#(
  parameter int W = 8,
  localparam int NG = grp_cnt(W)
) (
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [NG-1:0] cy_i,
  input logic [1:0]    op_i,
  input logic [W-1:0]  res_o,
  input logic [NG-1:0] cy_o,
  input logic          ov_o
);

  logic         cin;
  logic [W:0]   wide;
  logic         unused_low;

  assign cin        = cy_i[NG-1];
  assign unused_low = ^cy_i;

  always_comb begin
    wide = '0;
    if (!$isunknown({a_i, b_i, cin, op_i, res_o, cy_o, ov_o})) begin
      if (op_i == 2'b11) begin
        assert_clr_quiet_R6: assert (res_o == '0 && cy_o == '0 && !ov_o)
          else $error("clear op left outputs active");
      end else if (op_i == 2'b10) begin
        wide = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin};
        assert_sub_word_R4: assert (res_o == wide[W-1:0] && cy_o[NG-1] == wide[W])
          else $error("subtract word/borrow mismatch");
        assert_sub_ovf_R5: assert (ov_o == ((a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1])))
          else $error("subtract overflow mismatch");
      end else begin
        wide = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, (op_i == 2'b01) & cin};
        assert_add_word_R3: assert (res_o == wide[W-1:0] && cy_o[NG-1] == wide[W])
          else $error("add word/carry mismatch");
        assert_add_ovf_R5: assert (ov_o == ((a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1])))
          else $error("add overflow mismatch");
        if (op_i == 2'b00) begin
          // lowest group carry from a masked sum (R1, R2)
          assert_add_grp0_R1: assert (cy_o[0] ==
              ((int'(a_i) % (1 << grp_edge(W, 0))) + (int'(b_i) % (1 << grp_edge(W, 0)))
               >= (1 << grp_edge(W, 0))))
            else $error("group 0 carry mismatch");
        end
      end
    end
  end

endmodule

bind nibble_addsub nibble_addsub_chk #(.W(W)) u_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .cy_i (cy_i),
  .op_i (op_i),
  .res_o(res_o),
  .cy_o (cy_o),
  .ov_o (ov_o)
);

// File: tb/tb_nibble_addsub.sv
`timescale 1ns/1ps
module tb_nibble_addsub;

  localparam int MAXW  = 8;
  localparam int LIMIT = 150000;

  logic clk;
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  logic [MAXW-1:0] done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // R9: one combinational instance per width, each swept exhaustively
  for (genvar gw = 1; gw <= MAXW; gw++) begin : g_w
    localparam int WW  = gw;
    localparam int NGW = (WW - 1) / 4 + 1;

    logic [WW-1:0]  a_s, b_s, res;
    logic [NGW-1:0] cy_s, cy;
    logic           ov_s, ov;
    logic [1:0]     op_s;

    nibble_addsub #(.W(WW)) dut (
      .a_i  (a_s),
      .b_i  (b_s),
      .cy_i (cy_s),
      .ov_i (ov_s),
      .op_i (op_s),
      .res_o(res),
      .cy_o (cy),
      .ov_o (ov)
    );

    initial begin
      logic stop;
      stop    = 1'b0;
      done[gw-1] = 1'b0;
      for (int a = 0; a < (1 << WW) && !stop; a++)
        for (int b = 0; b < (1 << WW) && !stop; b++)
          for (int op = 0; op < 4 && !stop; op++)
            for (int ci = 0; ci < 2 && !stop; ci++) begin
              int k, c, am, bm, full, lowc;
              logic [WW-1:0]  eres;
              logic [NGW-1:0] ecy;
              logic           eov;
              a_s  = WW'(a);
              b_s  = WW'(b);
              op_s = 2'(op);
              // R7: lower carry bits and ov_i scrambled, must not matter
              cy_s = NGW'(a ^ (b << 1));
              cy_s[NGW-1] = ci[0];
              ov_s = ((a ^ b ^ ci) & 1) != 0;
              c = (op == 0) ? 0 : ci;
              // R1: group h closes at bit min(4(h+1), W)
              for (int h = 0; h < NGW; h++) begin
                k  = ((h + 1) * 4 < WW) ? (h + 1) * 4 : WW;
                am = a % (1 << k);
                bm = b % (1 << k);
                if (op == 2) ecy[h] = (am - bm - c) < 0;
                else         ecy[h] = (am + bm + c) >= (1 << k);
              end
              am = a % (1 << (WW - 1));
              bm = b % (1 << (WW - 1));
              if (op == 2) begin
                full = ((a - b - c) < 0) ? 1 : 0;
                lowc = ((am - bm - c) < 0) ? 1 : 0;
                eres = WW'(a - b - c);
              end else begin
                full = ((a + b + c) >= (1 << WW)) ? 1 : 0;
                lowc = ((am + bm + c) >= (1 << (WW - 1))) ? 1 : 0;
                eres = WW'(a + b + c);
              end
              eov = (full ^ lowc) != 0;   // R5, R8 when WW==1
              if (op == 3) begin          // R6
                eres = '0;
                ecy  = '0;
                eov  = 1'b0;
              end
              #0.25;
              n_cmp++;
              if (res !== eres || cy !== ecy || ov !== eov) begin
                n_bad++;
                stop = 1'b1;
                $display("FAIL %s W=%0d a=%0d b=%0d op=%0d cin=%0d: got res=%0d cy=%b ov=%b, exp res=%0d cy=%b ov=%b",
                         (op == 0) ? "R2/R7" : (op == 1) ? "R3/R5" : (op == 2) ? "R4/R5" : "R6",
                         WW, a, b, op, ci, res, cy, ov, eres, ecy, eov);
                if (WW == 1) $display("FAIL R8 single-bit width mismatch above (got ov=%b exp ov=%b)", ov, eov);
              end
              #0.25;
            end
      done[gw-1] = 1'b1;
    end
  end

  initial begin
    wait ((&done === 1'b1) || cyc >= LIMIT);
    if (&done !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 watchdog expired at cycle %0d: got unfinished, exp all widths done", cyc);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule